// File: doc/BRIEF.md
# I2C Channel-Select Switch Controller

This block is the digital core of a downstream bus switch. It listens on a two-wire I2C bus as a target device and keeps one byte that picks which of eight downstream channels are connected. It samples SCL and SDA on its own system clock and recognises START and STOP conditions. It matches a 7-bit address whose upper four bits are fixed at `1110` and whose three low bits come from strap pins. It answers reads with the stored byte.

Written bytes are staged in the channel register and never reach the `chan_en` outputs directly. The register is copied to the outputs only when a STOP is seen, so a downstream channel is connected only while every line is idle-high.

The state machine has eight states. IDLE waits for START. ADDR shifts in the address byte and goes to ADDR_ACK on a hit or to SKIP on a miss. ADDR_ACK goes to WR_BYTE or RD_BYTE according to the direction bit. WR_BYTE and WR_ACK alternate while the master writes. RD_BYTE goes to RD_ACK, and RD_ACK goes back to RD_BYTE on a master ACK or to SKIP on a master NACK. SKIP ignores the bus. A START from any state goes to ADDR, and a STOP from any state goes to IDLE.

Top module: `i2c_chsel_ctrl`

## Requirements
- R1: The block pulls SDA low during the ninth clock when the address byte carries the address {1110, strap[2], strap[1], strap[0]} in bits 7..1, sent MSB first. For any other address it leaves SDA released and ignores the bus until the next START or STOP.
- R2: After a write address is acknowledged, every complete data byte goes into the channel register, and the block acknowledges it by driving SDA low during the ninth clock.
- R3: When one transaction writes several bytes, the register holds the last complete byte.
- R4: `chan_en` changes only in response to a STOP condition, when it takes the register value. Bit n of that value enables channel n, and any combination of bits is allowed.
- R5: On a read, the block sends the current register value MSB first. This includes a value written but not yet applied by a STOP.
- R6: After a read byte, a master ACK (SDA low on the ninth clock) makes the block send the same register value again. A master NACK makes it release SDA and ignore the bus until the next START or STOP.
- R7: A repeated START in the middle of a data byte discards the partial byte and leaves the register unchanged. Address matching starts again.
- R8: While `rst_n` is low, the register and `chan_en` are zero and the bus state machine is in IDLE.
- R9: After reset, `chan_en` is 0 and `sda_pull` is 0.
- R10: Bit 0 of the address byte gives the direction: 1 means read and 0 means write.
- R11: When STOP is seen in the same cycle that a completed byte is being stored, the new byte is stored and is also the value applied to `chan_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| strap | input | 3 | Low three address bits from strap pins |
| sda_pull | output | 1 | 1 pulls SDA low (open-drain enable) |
| chan_en | output | 8 | Applied channel enables, bit n = channel n |

## Verification
The storing of a completed write byte and the detection of a STOP can fall in the same cycle. This happens when the master drives bit 0 as a zero and raises SDA one system clock after the eighth SCL rise, so the STOP event reaches the register bank together with the byte strobe. The bench provokes exactly this timing. It expects the new byte both in the register, which it reads back afterwards, and on `chan_en` three clocks after the SDA rise. A cycle-by-cycle model of `chan_en` is compared on every clock throughout the run.

// File: rtl/i2c_chsel_pkg.sv
package i2c_chsel_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_SKIP
    } sw_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic scl;
        logic sda;
    } bus_evt_t;

endpackage

// File: rtl/i2c_bus_sampler.sv
module i2c_bus_sampler
    import i2c_chsel_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_in,
    input  logic     sda_in,
    output bus_evt_t evt
);

    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] scl_sh;
    logic [TOP:0] sda_sh;
    logic         scl_p;
    logic         sda_p;
    logic         scl_now;
    logic         sda_now;

    // idle-high reset value keeps the first cycles free of false events
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_p  <= 1'b1;
            sda_p  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[TOP-1:0], scl_in};
            sda_sh <= {sda_sh[TOP-1:0], sda_in};
            scl_p  <= scl_sh[TOP];
            sda_p  <= sda_sh[TOP];
        end
    end

    assign scl_now = scl_sh[TOP];
    assign sda_now = sda_sh[TOP];

    always_comb begin
        evt.scl      = scl_now;
        evt.sda      = sda_now;
        evt.scl_rise = scl_now & ~scl_p;
        evt.scl_fall = ~scl_now & scl_p;
        evt.start    = scl_now & scl_p & sda_p & ~sda_now;
        evt.stop     = scl_now & scl_p & ~sda_p & sda_now;
    end

endmodule

// File: rtl/i2c_chsel_fsm.sv
module i2c_chsel_fsm
    import i2c_chsel_pkg::*;
#(
    parameter int         DW      = 8,
    parameter logic [3:0] ADDR_HI = 4'b1110
) (
    input  logic          clk,
    input  logic          rst_n,
    input  bus_evt_t      evt,
    input  logic [2:0]    strap,
    input  logic [DW-1:0] rd_data,
    output logic          wr_stb,
    output logic [DW-1:0] wr_data,
    output logic          sda_pull,
    output sw_state_e     state
);

    localparam int CW = $clog2(DW);

    sw_state_e     nxt;
    logic [CW-1:0] bit_cnt;
    logic [DW-1:0] shreg;
    logic [DW-1:0] rx_byte;
    logic          phase;
    logic          is_rd;
    logic          mack;
    logic          last_bit;
    logic          addr_hit;

    assign last_bit = (bit_cnt == CW'(DW - 1));
    assign rx_byte  = {shreg[DW-2:0], evt.sda};
    assign addr_hit = (rx_byte[DW-1:1] == {ADDR_HI, strap});
    assign wr_data  = shreg;

    // next-state logic
    always_comb begin
        nxt = state;
        if (evt.start) begin
            nxt = ST_ADDR;
        end else if (evt.stop) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:     nxt = ST_IDLE;
                ST_ADDR:     if (evt.scl_rise && last_bit)
                                 nxt = addr_hit ? ST_ADDR_ACK : ST_SKIP;
                ST_ADDR_ACK: if (evt.scl_fall && phase)
                                 nxt = is_rd ? ST_RD_BYTE : ST_WR_BYTE;
                ST_WR_BYTE:  if (evt.scl_rise && last_bit) nxt = ST_WR_ACK;
                ST_WR_ACK:   if (evt.scl_fall && phase) nxt = ST_WR_BYTE;
                ST_RD_BYTE:  if (evt.scl_fall && phase) nxt = ST_RD_ACK;
                ST_RD_ACK:   if (evt.scl_fall && phase)
                                 nxt = mack ? ST_RD_BYTE : ST_SKIP;
                ST_SKIP:     nxt = ST_SKIP;
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // shift, count and phase registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
            phase   <= 1'b0;
            is_rd   <= 1'b0;
            mack    <= 1'b0;
            wr_stb  <= 1'b0;
        end else begin
            wr_stb <= 1'b0;
            if (evt.start || evt.stop) begin
                bit_cnt <= '0;
                phase   <= 1'b0;
            end else begin
                unique case (state)
                    ST_ADDR: begin
                        if (evt.scl_rise) begin
                            shreg   <= rx_byte;
                            bit_cnt <= bit_cnt + 1'b1;
                            if (last_bit) begin
                                is_rd <= evt.sda;
                                phase <= 1'b0;
                            end
                        end
                    end
                    ST_ADDR_ACK, ST_WR_ACK: begin
                        if (evt.scl_fall) begin
                            if (!phase) begin
                                phase <= 1'b1;
                            end else begin
                                phase   <= 1'b0;
                                bit_cnt <= '0;
                                if (state == ST_ADDR_ACK && is_rd) shreg <= rd_data;
                            end
                        end
                    end
                    ST_WR_BYTE: begin
                        if (evt.scl_rise) begin
                            shreg   <= rx_byte;
                            bit_cnt <= bit_cnt + 1'b1;
                            if (last_bit) wr_stb <= 1'b1;
                        end
                    end
                    ST_RD_BYTE: begin
                        if (evt.scl_rise) begin
                            bit_cnt <= bit_cnt + 1'b1;
                            if (last_bit) phase <= 1'b1;
                        end else if (evt.scl_fall) begin
                            if (phase) phase <= 1'b0;
                            else       shreg <= {shreg[DW-2:0], 1'b1};
                        end
                    end
                    ST_RD_ACK: begin
                        if (evt.scl_rise) begin
                            mack  <= ~evt.sda;
                            phase <= 1'b1;
                        end else if (evt.scl_fall && phase) begin
                            phase   <= 1'b0;
                            bit_cnt <= '0;
                            shreg   <= rd_data;
                        end
                    end
                    ST_IDLE, ST_SKIP: begin
                        bit_cnt <= '0;
                    end
                    default: begin
                        bit_cnt <= '0;
                    end
                endcase
            end
        end
    end

    // output decode
    always_comb begin
        unique case (state)
            ST_ADDR_ACK, ST_WR_ACK: sda_pull = phase;
            ST_RD_BYTE:             sda_pull = ~shreg[DW-1];
            default:                sda_pull = 1'b0;
        endcase
    end

endmodule

// File: rtl/chsel_regs.sv
module chsel_regs #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_stb,
    input  logic [NCH-1:0] wr_data,
    input  logic           stop,
    output logic [NCH-1:0] ctrl_q,
    output logic [NCH-1:0] chan_en
);

    logic [NCH-1:0] apply_val;

    // a byte finishing in the STOP cycle is forwarded straight to the outputs
    assign apply_val = wr_stb ? wr_data : ctrl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            chan_en <= '0;
        end else begin
            if (wr_stb) ctrl_q  <= wr_data;
            if (stop)   chan_en <= apply_val;
        end
    end

endmodule

// File: rtl/i2c_chsel_ctrl.sv
module i2c_chsel_ctrl
    import i2c_chsel_pkg::*;
#(
    parameter int         NCH         = 8,
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] ADDR_HI     = 4'b1110
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           scl_in,
    input  logic           sda_in,
    input  logic [2:0]     strap,
    output logic           sda_pull,
    output logic [NCH-1:0] chan_en
);

    bus_evt_t       evt;
    sw_state_e      fsm_state;
    logic           wr_stb;
    logic [NCH-1:0] wr_data;
    logic [NCH-1:0] ctrl_q;

    i2c_bus_sampler #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sampler (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .evt    (evt)
    );

    i2c_chsel_fsm #(
        .DW      (NCH),
        .ADDR_HI (ADDR_HI)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt),
        .strap    (strap),
        .rd_data  (ctrl_q),
        .wr_stb   (wr_stb),
        .wr_data  (wr_data),
        .sda_pull (sda_pull),
        .state    (fsm_state)
    );

    chsel_regs #(
        .NCH(NCH)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_stb),
        .wr_data (wr_data),
        .stop    (evt.stop),
        .ctrl_q  (ctrl_q),
        .chan_en (chan_en)
    );

endmodule

// File: rtl/i2c_chsel_sva.sv
module i2c_chsel_sva
    import i2c_chsel_pkg::*;
#(
    parameter int NCH = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           scl_s,
    input logic           start_evt,
    input logic           stop_evt,
    input logic           sda_pull,
    input logic [NCH-1:0] chan_en,
    input logic [NCH-1:0] ctrl_q,
    input sw_state_e      state
);

    // R8
    always @(posedge clk) begin
        if (!rst_n) begin
            rst_clear_chk: assert (chan_en == '0 && ctrl_q == '0 && state == ST_IDLE);
        end
    end

    // R4
    en_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(chan_en) |-> $past(stop_evt));

    // R1
    pull_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> !scl_s);

    // R7
    start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> !sda_pull);

    // R2
    reg_write_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_q) |-> ($past(state) == ST_WR_ACK));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IDLE |-> !sda_pull);

endmodule

bind i2c_chsel_ctrl i2c_chsel_sva #(.NCH(NCH)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (evt.scl),
    .start_evt (evt.start),
    .stop_evt  (evt.stop),
    .sda_pull  (sda_pull),
    .chan_en   (chan_en),
    .ctrl_q    (ctrl_q),
    .state     (fsm_state)
);

// File: tb/tb_i2c_chsel_ctrl.sv
`timescale 1ns/1ps
module tb_i2c_chsel_ctrl;

    localparam int H = 8;
    localparam int Q = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       m_sda = 1'b1;
    logic [2:0] strap = 3'b010;
    logic       sda_pull;
    logic [7:0] chan_en;
    wire        sda_bus = m_sda & ~sda_pull;

    int n_chk = 0;
    int n_bad = 0;
    int exp_en = 0;
    int exp_ctrl = 0;
    bit run = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    i2c_chsel_ctrl dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl),
        .sda_in   (sda_bus),
        .strap    (strap),
        .sda_pull (sda_pull),
        .chan_en  (chan_en)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h @%0t", tag, act, exp, $time);
        end
    endtask

    // R4: per-clock reference of the applied channel enables
    always @(posedge clk) begin
        #2;
        if (run) begin
            n_chk++;
            if (chan_en !== exp_en[7:0]) begin
                n_bad++;
                $display("FAIL R4 chan_en act=%0h exp=%0h @%0t", chan_en, exp_en[7:0], $time);
            end
        end
    end

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b0; wclk(H);
        scl = 1'b0;   wclk(H);
    endtask

    task automatic bus_rstart();
        m_sda = 1'b1; wclk(Q);
        scl = 1'b1;   wclk(H);
        m_sda = 1'b0; wclk(H);
        scl = 1'b0;   wclk(H);
    endtask

    task automatic bus_stop();
        wclk(Q);
        m_sda = 1'b0; wclk(Q);
        scl = 1'b1;   wclk(H);
        m_sda = 1'b1;
        repeat (3) @(posedge clk);
        exp_en = exp_ctrl;
        wclk(H);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            wclk(Q); m_sda = b[i]; wclk(Q);
            scl = 1'b1; wclk(H);
            scl = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        wclk(Q); m_sda = 1'b1; wclk(Q);
        scl = 1'b1; wclk(Q);
        ack = sda_bus; wclk(Q);
        scl = 1'b0;
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        wclk(Q); m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wclk(H);
            scl = 1'b1; wclk(Q);
            b[i] = sda_bus; wclk(Q);
            scl = 1'b0;
        end
        wclk(Q); m_sda = give_ack ? 1'b0 : 1'b1; wclk(Q);
        scl = 1'b1; wclk(H);
        scl = 1'b0; wclk(Q);
        m_sda = 1'b1;
    endtask

    function automatic logic [7:0] addr_byte(input logic [2:0] pins, input bit rd);
        return {4'b1110, pins, rd};
    endfunction

    task automatic write_txn(input logic [7:0] d, input bit do_stop);
        logic a;
        bus_start();
        send_byte(addr_byte(strap, 1'b0), a);
        chk(a == 1'b0, "R1 addr ack", a, 0);
        send_byte(d, a);
        chk(a == 1'b0, "R2 data ack", a, 0);
        exp_ctrl = d;
        if (do_stop) bus_stop();
    endtask

    task automatic read_txn(input int exp_val);
        logic       a;
        logic [7:0] r;
        bus_start();
        send_byte(addr_byte(strap, 1'b1), a);
        chk(a == 1'b0, "R10 read addr ack", a, 0);
        recv_byte(1'b0, r);
        chk(r == exp_val[7:0], "R5 read value", r, exp_val);
        bus_stop();
    endtask

    initial begin : main
        logic       a;
        logic [7:0] r;
        logic [7:0] pat;
        wclk(3);
        // R9 / R8: state held in reset
        chk(chan_en == 8'h00, "R8 chan_en in reset", chan_en, 0);
        rst_n = 1'b1;
        run = 1'b1;
        wclk(3);
        chk(chan_en == 8'h00, "R9 chan_en after reset", chan_en, 0);
        chk(sda_pull == 1'b0, "R9 sda_pull after reset", sda_pull, 0);

        // R1: wrong address ignored
        bus_start();
        send_byte({4'b1110, 3'b011, 1'b0}, a);
        chk(a == 1'b1, "R1 foreign addr nack", a, 1);
        send_byte(8'hFF, a);
        chk(a == 1'b1, "R1 foreign data ignored", a, 1);
        bus_stop();
        chk(chan_en == 8'h00, "R1 no change after foreign write", chan_en, 0);

        // R2 / R4: single write, applied only at STOP
        write_txn(8'hA5, 1'b0);
        wclk(H);
        chk(chan_en == 8'h00, "R4 held before stop", chan_en, 0);
        bus_stop();
        chk(chan_en == 8'hA5, "R4 applied at stop", chan_en, 8'hA5);

        // R3: last byte of several wins
        bus_start();
        send_byte(addr_byte(strap, 1'b0), a);
        send_byte(8'h11, a);
        send_byte(8'h3C, a);
        send_byte(8'h80, a);
        chk(a == 1'b0, "R2 third byte ack", a, 0);
        exp_ctrl = 8'h80;
        bus_stop();
        chk(chan_en == 8'h80, "R3 last byte kept", chan_en, 8'h80);

        // R5 / R10: read back
        read_txn(8'h80);

        // R5 / R6: pending value read, master ACK repeats
        write_txn(8'h42, 1'b0);
        bus_rstart();
        send_byte(addr_byte(strap, 1'b1), a);
        chk(a == 1'b0, "R10 read after rstart ack", a, 0);
        recv_byte(1'b1, r);
        chk(r == 8'h42, "R5 pending value read", r, 8'h42);
        recv_byte(1'b0, r);
        chk(r == 8'h42, "R6 repeat after master ack", r, 8'h42);
        wclk(H);
        chk(sda_pull == 1'b0, "R6 released after nack", sda_pull, 0);
        bus_stop();
        chk(chan_en == 8'h42, "R4 applied after read stop", chan_en, 8'h42);

        // R4: independent channel bits
        for (int k = 0; k < 8; k++) begin
            pat = 8'h01 << k;
            write_txn(pat, 1'b1);
            chk(chan_en == pat, "R4 one-hot channel", chan_en, pat);
        end
        write_txn(8'hFF, 1'b1);
        chk(chan_en == 8'hFF, "R4 all channels", chan_en, 8'hFF);

        // R7: partial byte cut by repeated START
        bus_start();
        send_byte(addr_byte(strap, 1'b0), a);
        send_bits(8'h0F, 4);
        bus_rstart();
        send_byte(addr_byte(strap, 1'b1), a);
        recv_byte(1'b0, r);
        chk(r == 8'hFF, "R7 partial byte discarded", r, 8'hFF);
        bus_stop();
        chk(chan_en == 8'hFF, "R7 outputs unchanged", chan_en, 8'hFF);

        // R1: new strap value
        strap = 3'b101;
        bus_start();
        send_byte({4'b1110, 3'b010, 1'b0}, a);
        chk(a == 1'b1, "R1 old strap nack", a, 1);
        bus_stop();
        write_txn(8'h0C, 1'b1);
        chk(chan_en == 8'h0C, "R1 new strap write", chan_en, 8'h0C);

        // R11: STOP coinciding with byte store
        bus_start();
        send_byte(addr_byte(strap, 1'b0), a);
        send_bits(8'h5A, 7);
        wclk(Q); m_sda = 1'b0; wclk(Q);
        scl = 1'b1; wclk(1);
        m_sda = 1'b1;
        exp_ctrl = 8'h5A;
        repeat (3) @(posedge clk);
        exp_en = exp_ctrl;
        wclk(H);
        chk(chan_en == 8'h5A, "R11 coincident stop applies byte", chan_en, 8'h5A);
        read_txn(8'h5A);

        // R8: reset mid-transaction
        write_txn(8'h77, 1'b0);
        rst_n = 1'b0;
        exp_ctrl = 0;
        exp_en = 0;
        wclk(2);
        chk(chan_en == 8'h00, "R8 reset clears outputs", chan_en, 0);
        rst_n = 1'b1;
        wclk(2);
        bus_stop();
        read_txn(0);
        chk(chan_en == 8'h00, "R8 register cleared", chan_en, 0);

        run = 1'b0;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule